// File: doc/BRIEF.md
# PCI Target Responder for One I/O Function

This block is the target side of one function on a PCI bus. It watches the start of every bus transaction and claims two kinds of access. The first is a configuration read or write with the select line for this function high. The second is an I/O read or write whose address falls inside a relocatable 32-byte window. It answers with DEVSEL, TRDY and STOP, and each of these appears after a fixed number of clocks. Every access is a single data beat. The byte enables choose which lanes of a 32-bit word a write updates.

Configuration space holds three registers. The first is a read-only identity word. The second is a command word whose bit 0 enables I/O decoding. The third is a base address register that places the I/O window. The window maps onto a bank of 32-bit registers. A master can lock the function. While the lock holds, an I/O access from any other master is retried: DEVSEL and STOP are driven and TRDY stays low. All pins that are active low on the bus are active-high enables here, and every output is registered.

Top module: `pci_tgt_resp`

## Requirements
- R1: While reset is applied and after it is released, devsel_o, trdy_o, stop_o and ad_oe are all low. The command word reads 0 and the base address register reads 00000001h.
- R2: Count the rising edge that first samples frame_i high as edge 0. For every claimed access, devsel_o is first high after edge 2.
- R3: A configuration access is claimed only when idsel_i is high on edge 0 and cbe_i on edge 0 is 1010b (read) or 1011b (write). trdy_o is first high after edge 3.
- R4: Configuration word offsets are taken from ad_i[7:2]. Offset 00h returns the DEV_ID parameter. Offset 04h is the command word, and only its bit 0 (I/O enable) is writable; its other bits read 0. Offset 10h is the base address register. Every other offset reads 0.
- R5: The base address register stores bits 31..5. Bits 4..1 always read 0 and bit 0 always reads 1. Writing FFFFFFFFh reads back as FFFFFFE1h.
- R6: An I/O access is claimed only when the command word's bit 0 is 1 and ad_i[31:5] equals the stored base address bits. Register index = ad_i[4:2].
- R7: A claimed I/O access first shows trdy_o high after edge 8. That is edge 2 for DEVSEL plus 6 wait states.
- R8: During a write data phase, byte lane n (ad_i[8n+7:8n]) is written only when cbe_i[n] is 0. Lane 0 is ad_i[7:0] and lane 3 is ad_i[31:24]. This holds for I/O registers and for the base address register.
- R9: An address that falls inside the I/O window with a command other than 0010b (I/O read) or 0011b (I/O write) is not claimed: devsel_o stays low.
- R10: A data phase completes on the edge where trdy_o and irdy_i are both high. Until then trdy_o and devsel_o hold. After the completion edge, devsel_o and trdy_o are low.
- R11: While the function is locked, a claimed I/O access that has lock_i high on edge 0 is retried. devsel_o and stop_o are first high after edge 2, trdy_o stays low, no register changes, and both drop after the edge that samples irdy_i high.
- R12: A claimed I/O access with lock_i low on edge 0 and high on edge 1 locks the function when it completes. Such an owner access is served normally while the lock holds. The lock is released on any idle edge that samples frame_i and lock_i both low.
- R13: ad_oe is high only while trdy_o is high during a read. ad_o then carries the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Transaction in progress (active-high form of FRAME) |
| irdy_i | input | 1 | Initiator ready |
| idsel_i | input | 1 | Configuration select for this function |
| lock_i | input | 1 | Bus lock held by a master |
| cbe_i | input | 4 | Command on edge 0, byte enables (0 = lane used) in the data phase |
| ad_i | input | 32 | Address on edge 0, write data in the data phase |
| ad_o | output | 32 | Read data |
| ad_oe | output | 1 | Drive enable for ad_o |
| devsel_o | output | 1 | Device selected |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target requests stop (retry) |

## Verification
The bench builds the block with its default timing: DEVSEL after 2 edges, configuration TRDY after 3, and 6 I/O wait states, which places I/O TRDY after edge 8. These values make the bench observe, on every access, exact edge counts that differ between the two access kinds. The window is 32 bytes. With this size, an address one window above the base lands just outside the window, and the BAR masking test can show the bits that read as zero. DEV_ID is overridden with a value of the bench's own, so the identity read is checked against a value that is not the default. The initiator's IRDY delay is made longer than the I/O wait period, so the hold of TRDY through extra wait states is observed.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam logic [5:0] CFG_IDX_ID  = 6'd0;
  localparam logic [5:0] CFG_IDX_CMD = 6'd1;
  localparam logic [5:0] CFG_IDX_BAR = 6'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_RETRY
  } tgt_state_e;

  // Replace the lanes whose active-low enable is 0.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  cbe_n);
    logic [31:0] res;
    for (int b = 0; b < 4; b++) begin
      res[8*b +: 8] = cbe_n[b] ? old_w[8*b +: 8] : new_w[8*b +: 8];
    end
    return res;
  endfunction

  // Address falls inside the window whose low bits are covered by low_mask.
  function automatic logic window_hit(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input logic [31:0] low_mask);
    return ((addr ^ base) & ~low_mask) == 32'd0;
  endfunction

  // BAR view: low bits zero, bit 0 marks I/O space.
  function automatic logic [31:0] bar_readback(input logic [31:0] base,
                                               input logic [31:0] low_mask);
    return (base & ~low_mask) | 32'd1;
  endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int WIN_BITS = 5
) (
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic        idsel_i,
  input  logic        ioen,
  input  logic [31:0] bar_base,
  output logic        cfg_hit,
  output logic        io_hit,
  output logic        is_write
);
  localparam logic [31:0] LOW_MASK = (32'd1 << WIN_BITS) - 32'd1;

  logic is_cfg_cmd;
  logic is_io_cmd;

  always_comb begin
    is_cfg_cmd = (cbe_i == CMD_CFG_RD) || (cbe_i == CMD_CFG_WR);
    is_io_cmd  = (cbe_i == CMD_IO_RD)  || (cbe_i == CMD_IO_WR);
    cfg_hit    = idsel_i && is_cfg_cmd;
    io_hit     = ioen && is_io_cmd && window_hit(ad_i, bar_base, LOW_MASK);
    is_write   = (cbe_i == CMD_CFG_WR) || (cbe_i == CMD_IO_WR);
  end
endmodule

// File: rtl/pci_tgt_cfg.sv
module pci_tgt_cfg
  import pci_tgt_pkg::*;
#(
  parameter int          WIN_BITS = 5,
  parameter logic [31:0] DEV_ID   = 32'h7A11_C0DE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  idx,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic [3:0]  cbe_n,
  output logic [31:0] rdata,
  output logic        ioen,
  output logic [31:0] bar_base
);
  localparam logic [31:0] LOW_MASK = (32'd1 << WIN_BITS) - 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioen     <= 1'b0;
      bar_base <= 32'd0;
    end else if (we) begin
      case (idx)
        CFG_IDX_CMD: if (!cbe_n[0]) ioen <= wdata[0];
        CFG_IDX_BAR: bar_base <= lane_merge(bar_base, wdata, cbe_n) & ~LOW_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      CFG_IDX_ID:  rdata = DEV_ID;
      CFG_IDX_CMD: rdata = {31'd0, ioen};
      CFG_IDX_BAR: rdata = bar_readback(bar_base, LOW_MASK);
      default:     rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile
  import pci_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic [31:0]      wdata,
  input  logic [3:0]       cbe_n,
  output logic [31:0]      rdata
);
  logic [31:0] words [NUM_REGS];

  for (genvar w = 0; w < NUM_REGS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= 32'd0;
      end else if (we && (idx == IDX_W'(w))) begin
        word_q <= lane_merge(word_q, wdata, cbe_n);
      end
    end
    assign words[w] = word_q;
  end

  assign rdata = words[idx];
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int DEVSEL_LAT   = 2,
  parameter int CFG_TRDY_LAT = 3,
  parameter int IO_TRDY_LAT  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_i,
  input  logic        irdy_i,
  input  logic        lock_i,
  input  logic [5:0]  word_addr,
  input  logic        cfg_hit,
  input  logic        io_hit,
  input  logic        is_write,
  input  logic [31:0] rd_data,
  output logic [5:0]  addr_q,
  output logic        wr_q,
  output logic        kind_io,
  output logic        devsel_o,
  output logic        trdy_o,
  output logic        stop_o,
  output logic        ad_oe,
  output logic [31:0] ad_o,
  output logic        start_evt,
  output logic        xfer_done,
  output logic        retry_done
);
  localparam int MAX_LAT = (IO_TRDY_LAT > CFG_TRDY_LAT) ? IO_TRDY_LAT : CFG_TRDY_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] DEV_C = CNT_W'(DEVSEL_LAT);
  localparam logic [CNT_W-1:0] CFG_C = CNT_W'(CFG_TRDY_LAT);
  localparam logic [CNT_W-1:0] IO_C  = CNT_W'(IO_TRDY_LAT);

  tgt_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] trdy_lat;
  logic             frame_q;
  logic             locked;
  logic             lock_at_addr;
  logic             lock_req;

  assign trdy_lat   = kind_io ? IO_C : CFG_C;
  assign start_evt  = (st == ST_IDLE) && frame_i && !frame_q;
  assign xfer_done  = (st == ST_CLAIM) && trdy_o && irdy_i;
  assign retry_done = (st == ST_RETRY) && stop_o && irdy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      frame_q      <= 1'b0;
      locked       <= 1'b0;
      lock_at_addr <= 1'b0;
      lock_req     <= 1'b0;
      addr_q       <= '0;
      wr_q         <= 1'b0;
      kind_io      <= 1'b0;
      devsel_o     <= 1'b0;
      trdy_o       <= 1'b0;
      stop_o       <= 1'b0;
      ad_oe        <= 1'b0;
      ad_o         <= 32'd0;
    end else begin
      frame_q <= frame_i;
      case (st)
        ST_IDLE: begin
          if (!frame_i && !lock_i) locked <= 1'b0;
          if (start_evt) begin
            addr_q       <= word_addr;
            wr_q         <= is_write;
            kind_io      <= io_hit;
            lock_at_addr <= lock_i;
            lock_req     <= 1'b0;
            cnt          <= CNT_W'(1);
            if (io_hit && locked && lock_i) st <= ST_RETRY;
            else if (cfg_hit || io_hit)     st <= ST_CLAIM;
          end
        end
        ST_CLAIM: begin
          if (cnt < trdy_lat) cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(1)) lock_req <= kind_io && !lock_at_addr && lock_i;
          if (cnt == DEV_C) devsel_o <= 1'b1;
          if (cnt == trdy_lat && !trdy_o) begin
            trdy_o <= 1'b1;
            ad_oe  <= !wr_q;
            ad_o   <= rd_data;
          end
          if (xfer_done) begin
            devsel_o <= 1'b0;
            trdy_o   <= 1'b0;
            ad_oe    <= 1'b0;
            st       <= ST_IDLE;
            if (lock_req) locked <= 1'b1;
          end
        end
        ST_RETRY: begin
          if (cnt < DEV_C) cnt <= cnt + CNT_W'(1);
          if (cnt == DEV_C) begin
            devsel_o <= 1'b1;
            stop_o   <= 1'b1;
          end
          if (retry_done) begin
            devsel_o <= 1'b0;
            stop_o   <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_resp.sv
module pci_tgt_resp
  import pci_tgt_pkg::*;
#(
  parameter int          DEVSEL_LAT   = 2,
  parameter int          CFG_TRDY_LAT = 3,
  parameter int          IO_WAITS     = 6,
  parameter int          WIN_BYTES    = 32,
  parameter logic [31:0] DEV_ID       = 32'h7A11_C0DE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_i,
  input  logic        irdy_i,
  input  logic        idsel_i,
  input  logic        lock_i,
  input  logic [3:0]  cbe_i,
  input  logic [31:0] ad_i,
  output logic [31:0] ad_o,
  output logic        ad_oe,
  output logic        devsel_o,
  output logic        trdy_o,
  output logic        stop_o
);
  localparam int IO_TRDY_LAT = DEVSEL_LAT + IO_WAITS;
  localparam int WIN_BITS    = $clog2(WIN_BYTES);
  localparam int NUM_REGS    = WIN_BYTES / 4;
  localparam int IDX_W       = WIN_BITS - 2;

  logic        cfg_hit, io_hit, is_write;
  logic        ioen;
  logic [31:0] bar_base;
  logic [5:0]  addr_q;
  logic        wr_q, kind_io;
  logic        start_evt, xfer_done, retry_done;
  logic [31:0] cfg_rdata, io_rdata, rd_data;
  logic        cfg_we, io_we;

  pci_tgt_decode #(.WIN_BITS(WIN_BITS)) u_dec (
    .ad_i(ad_i), .cbe_i(cbe_i), .idsel_i(idsel_i), .ioen(ioen),
    .bar_base(bar_base), .cfg_hit(cfg_hit), .io_hit(io_hit), .is_write(is_write)
  );

  pci_tgt_fsm #(
    .DEVSEL_LAT(DEVSEL_LAT), .CFG_TRDY_LAT(CFG_TRDY_LAT), .IO_TRDY_LAT(IO_TRDY_LAT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i), .lock_i(lock_i),
    .word_addr(ad_i[7:2]), .cfg_hit(cfg_hit), .io_hit(io_hit), .is_write(is_write),
    .rd_data(rd_data), .addr_q(addr_q), .wr_q(wr_q), .kind_io(kind_io),
    .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o), .ad_oe(ad_oe), .ad_o(ad_o),
    .start_evt(start_evt), .xfer_done(xfer_done), .retry_done(retry_done)
  );

  assign cfg_we  = xfer_done && wr_q && !kind_io;
  assign io_we   = xfer_done && wr_q && kind_io;
  assign rd_data = kind_io ? io_rdata : cfg_rdata;

  pci_tgt_cfg #(.WIN_BITS(WIN_BITS), .DEV_ID(DEV_ID)) u_cfg (
    .clk(clk), .rst_n(rst_n), .idx(addr_q), .we(cfg_we), .wdata(ad_i),
    .cbe_n(cbe_i), .rdata(cfg_rdata), .ioen(ioen), .bar_base(bar_base)
  );

  pci_tgt_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx(addr_q[IDX_W-1:0]), .we(io_we), .wdata(ad_i),
    .cbe_n(cbe_i), .rdata(io_rdata)
  );
endmodule

// File: rtl/pci_tgt_checker.sv
module pci_tgt_checker #(
  parameter int DEVSEL_LAT   = 2,
  parameter int CFG_TRDY_LAT = 3,
  parameter int IO_TRDY_LAT  = 8
) (
  input logic clk,
  input logic rst_n,
  input logic irdy_i,
  input logic devsel_o,
  input logic trdy_o,
  input logic stop_o,
  input logic ad_oe,
  input logic start_evt,
  input logic xfer_done,
  input logic retry_done,
  input logic kind_io,
  input logic wr_q,
  input logic ioen
);
  logic [7:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_start <= 8'd0;
    else if (start_evt)            since_start <= 8'd1;
    else if (since_start != 8'hFF) since_start <= since_start + 8'd1;
  end

  p_devsel_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_o) |-> since_start == 8'(DEVSEL_LAT + 1));
  p_cfg_trdy_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy_o) && !kind_io |-> since_start == 8'(CFG_TRDY_LAT + 1));
  p_io_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    devsel_o && kind_io |-> ioen);
  p_io_trdy_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trdy_o) && kind_io |-> since_start == 8'(IO_TRDY_LAT + 1));
  p_trdy_with_devsel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_o |-> devsel_o);
  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_o && !irdy_i |=> trdy_o && devsel_o);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !devsel_o && !trdy_o);
  p_retry_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> devsel_o && !trdy_o);
  p_retry_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retry_done |=> !stop_o && !devsel_o);
  p_oe_read_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> trdy_o && !wr_q);
endmodule

bind pci_tgt_resp pci_tgt_checker #(
  .DEVSEL_LAT(DEVSEL_LAT), .CFG_TRDY_LAT(CFG_TRDY_LAT), .IO_TRDY_LAT(IO_TRDY_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irdy_i(irdy_i), .devsel_o(devsel_o), .trdy_o(trdy_o),
  .stop_o(stop_o), .ad_oe(ad_oe), .start_evt(start_evt), .xfer_done(xfer_done),
  .retry_done(retry_done), .kind_io(kind_io), .wr_q(wr_q), .ioen(ioen)
);

// File: tb/sim_pci_tgt_resp.sv
`timescale 1ns/1ps
module sim_pci_tgt_resp;
  localparam logic [31:0] ID_VAL = 32'h5EED_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_i = 1'b0, irdy_i = 1'b0, idsel_i = 1'b0, lock_i = 1'b0;
  logic [3:0]  cbe_i = 4'hF;
  logic [31:0] ad_i = 32'd0;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_o, trdy_o, stop_o;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;

  pci_tgt_resp #(.DEV_ID(ID_VAL)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i), .idsel_i(idsel_i),
    .lock_i(lock_i), .cbe_i(cbe_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  // One single-beat transaction; k counts edges after the address edge.
  task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic sel, input logic lk_addr, input logic lk_data,
                           input logic [31:0] wdata, input logic [3:0] be_n,
                           input int irdy_at, output logic [31:0] rdata,
                           output int dev_k, output int trdy_k, output int stop_k,
                           output int end_k, output logic oe_seen, output logic released);
    dev_k = -1; trdy_k = -1; stop_k = -1; end_k = -1; rdata = 32'd0; oe_seen = 1'b0;
    frame_i = 1'b1; ad_i = addr; cbe_i = cmd; idsel_i = sel; lock_i = lk_addr; irdy_i = 1'b0;
    @(negedge clk);
    frame_i = 1'b0; idsel_i = 1'b0; ad_i = wdata; cbe_i = be_n; lock_i = lk_data;
    irdy_i = (irdy_at <= 0);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (devsel_o && dev_k < 0) dev_k = k;
      if (trdy_o && trdy_k < 0) trdy_k = k;
      if (stop_o && stop_k < 0) stop_k = k;
      if (ad_oe) begin oe_seen = 1'b1; rdata = ad_o; end
      if (!irdy_i && k >= irdy_at) irdy_i = 1'b1;
      if (irdy_i && (trdy_o || stop_o)) begin end_k = k; break; end
    end
    @(negedge clk);
    released = !devsel_o && !trdy_o && !stop_o && !ad_oe;
    irdy_i = 1'b0; ad_i = 32'd0; cbe_i = 4'hF;
    @(negedge clk);
  endtask

  task automatic cfg_rd(input logic [7:0] off, output logic [31:0] d,
                        output int dk, output int tk);
    int sk, ek; logic oe, rel;
    bus_cycle(4'b1010, {24'd0, off}, 1'b1, lock_i, lock_i, 32'd0, 4'h0, 0, d, dk, tk, sk, ek, oe, rel);
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be_n);
    logic [31:0] r; int dk, tk, sk, ek; logic oe, rel;
    bus_cycle(4'b1011, {24'd0, off}, 1'b1, 1'b0, 1'b0, d, be_n, 0, r, dk, tk, sk, ek, oe, rel);
    check("R3", "cfg write claimed", 32'(tk), 32'd3);
    check("R13", "no drive on write", 32'(oe), 32'd0);
  endtask

  task automatic io_rd(input logic [31:0] a, output logic [31:0] d,
                       output int dk, output int tk);
    int sk, ek; logic oe, rel;
    bus_cycle(4'b0010, a, 1'b0, 1'b0, 1'b0, 32'd0, 4'h0, 0, d, dk, tk, sk, ek, oe, rel);
  endtask

  task automatic io_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be_n,
                       output int dk);
    logic [31:0] r; int tk, sk, ek; logic oe, rel;
    bus_cycle(4'b0011, a, 1'b0, 1'b0, 1'b0, d, be_n, 0, r, dk, tk, sk, ek, oe, rel);
  endtask

  task automatic t_reset();
    check("R1", "devsel idle", 32'(devsel_o), 32'd0);
    check("R1", "trdy idle", 32'(trdy_o), 32'd0);
    check("R1", "stop idle", 32'(stop_o), 32'd0);
    check("R1", "oe idle", 32'(ad_oe), 32'd0);
  endtask

  task automatic t_cfg_basics();
    logic [31:0] d; int dk, tk;
    cfg_rd(8'h00, d, dk, tk);
    check("R4", "identity word", d, ID_VAL);
    check("R2", "cfg devsel edge", 32'(dk), 32'd2);
    check("R3", "cfg trdy edge", 32'(tk), 32'd3);
    cfg_rd(8'h04, d, dk, tk);
    check("R1", "command after reset", d, 32'd0);
    cfg_rd(8'h10, d, dk, tk);
    check("R1", "BAR after reset", d, 32'h0000_0001);
    cfg_rd(8'h08, d, dk, tk);
    check("R4", "unused offset", d, 32'd0);
  endtask

  task automatic t_cfg_no_select();
    logic [31:0] r; int dk, tk, sk, ek; logic oe, rel;
    bus_cycle(4'b1010, 32'h0, 1'b0, 1'b0, 1'b0, 32'd0, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R3", "no claim without select", 32'(dk), 32'hFFFF_FFFF);
    bus_cycle(4'b0110, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R3", "no claim for memory read with select", 32'(dk), 32'hFFFF_FFFF);
  endtask

  task automatic t_bar_mask();
    logic [31:0] d; int dk, tk;
    cfg_wr(8'h10, 32'hFFFF_FFFF, 4'h0);
    cfg_rd(8'h10, d, dk, tk);
    check("R5", "BAR low bits masked", d, 32'hFFFF_FFE1);
    cfg_wr(8'h10, 32'h0000_1000, 4'h0);
    cfg_rd(8'h10, d, dk, tk);
    check("R5", "BAR relocated", d, 32'h0000_1001);
  endtask

  task automatic t_io_disabled();
    int dk;
    io_wr(32'h0000_1004, 32'h1234_5678, 4'h0, dk);
    check("R6", "no I/O claim with enable off", 32'(dk), 32'hFFFF_FFFF);
  endtask

  task automatic t_enable_and_io();
    logic [31:0] d; int dk, tk;
    cfg_wr(8'h04, 32'hFFFF_FFFF, 4'h0);
    cfg_rd(8'h04, d, dk, tk);
    check("R4", "only enable bit kept", d, 32'd1);
    io_rd(32'h0000_1004, d, dk, tk);
    check("R6", "write while disabled had no effect", d, 32'd0);
    io_wr(32'h0000_1004, 32'hA5A5_A5A5, 4'h0, dk);
    check("R6", "I/O write claimed", 32'(dk), 32'd2);
    io_rd(32'h0000_1004, d, dk, tk);
    check("R6", "I/O read back", d, 32'hA5A5_A5A5);
    check("R2", "I/O devsel edge", 32'(dk), 32'd2);
    check("R7", "I/O trdy edge", 32'(tk), 32'd8);
    io_wr(32'h0000_101C, 32'hCAFE_F00D, 4'h0, dk);
    io_rd(32'h0000_101C, d, dk, tk);
    check("R6", "top word of window", d, 32'hCAFE_F00D);
  endtask

  task automatic t_byte_lanes();
    logic [31:0] d; int dk, tk;
    io_wr(32'h0000_1004, 32'h1122_3344, 4'b1010, dk);
    io_rd(32'h0000_1004, d, dk, tk);
    check("R8", "lanes 0 and 2 only", d, 32'hA522_A544);
    io_wr(32'h0000_1004, 32'h99FF_FFFF, 4'b0111, dk);
    io_rd(32'h0000_1004, d, dk, tk);
    check("R8", "lane 3 only", d, 32'h9922_A544);
    cfg_wr(8'h10, 32'h0000_2000, 4'b1101);
    cfg_rd(8'h10, d, dk, tk);
    check("R8", "BAR lane 1 only", d, 32'h0000_2001);
    cfg_wr(8'h10, 32'h0000_1000, 4'h0);
  endtask

  task automatic t_miss_cases();
    logic [31:0] r; int dk, tk, sk, ek; logic oe, rel;
    io_rd(32'h0000_1020, r, dk, tk);
    check("R6", "address above window", 32'(dk), 32'hFFFF_FFFF);
    bus_cycle(4'b0110, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 32'd0, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R9", "memory read in window", 32'(dk), 32'hFFFF_FFFF);
    bus_cycle(4'b0111, 32'h0000_1004, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R9", "memory write in window", 32'(dk), 32'hFFFF_FFFF);
    io_rd(32'h0000_1004, r, dk, tk);
    check("R9", "register untouched", r, 32'h9922_A544);
  endtask

  task automatic t_wait_states();
    logic [31:0] r; int dk, tk, sk, ek; logic oe, rel;
    bus_cycle(4'b0010, 32'h0000_101C, 1'b0, 1'b0, 1'b0, 32'd0, 4'h0, 11, r, dk, tk, sk, ek, oe, rel);
    check("R10", "trdy still up when irdy arrives", 32'(ek), 32'd11);
    check("R10", "released after completion", 32'(rel), 32'd1);
    check("R13", "data driven on read", r, 32'hCAFE_F00D);
    check("R13", "drive seen on read", 32'(oe), 32'd1);
  endtask

  task automatic t_lock();
    logic [31:0] r; int dk, tk, sk, ek; logic oe, rel;
    bus_cycle(4'b0011, 32'h0000_1008, 1'b0, 1'b0, 1'b1, 32'h0B0B_0B0B, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R12", "locking write served", 32'(tk), 32'd8);
    bus_cycle(4'b0011, 32'h0000_1008, 1'b0, 1'b1, 1'b1, 32'hDEAD_DEAD, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R11", "retry devsel edge", 32'(dk), 32'd2);
    check("R11", "retry stop edge", 32'(sk), 32'd2);
    check("R11", "retry without trdy", 32'(tk), 32'hFFFF_FFFF);
    check("R11", "retry released", 32'(rel), 32'd1);
    bus_cycle(4'b0010, 32'h0000_1008, 1'b0, 1'b0, 1'b1, 32'd0, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R12", "owner read served", 32'(tk), 32'd8);
    check("R11", "retried write had no effect", r, 32'h0B0B_0B0B);
    cfg_rd(8'h00, r, dk, tk);
    check("R12", "config not retried while locked", r, ID_VAL);
    lock_i = 1'b0;
    @(negedge clk);
    bus_cycle(4'b0010, 32'h0000_1008, 1'b0, 1'b1, 1'b1, 32'd0, 4'h0, 0, r, dk, tk, sk, ek, oe, rel);
    check("R12", "after release no retry", 32'(sk), 32'hFFFF_FFFF);
    check("R12", "after release served", r, 32'h0B0B_0B0B);
    lock_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cfg_basics();
    t_cfg_no_select();
    t_bar_mask();
    t_io_disabled();
    t_enable_and_io();
    t_byte_lanes();
    t_miss_cases();
    t_wait_states();
    t_lock();
    finish_run();
  end
endmodule